// File: doc/BRIEF.md
# Dual-Compare 16-Bit Interval Timer

This peripheral is a 16-bit up-counter with two compare points. The high compare value sets the length of the interval. When the counter's next value equals it, the counter returns to zero and a high-compare interrupt is raised. The low compare value marks an event part way through the interval. It raises its own interrupt and the count is not disturbed. A timer output flip-flop can be set to invert on either match. The enables for that inversion affect only the flip-flop. They never suppress an interrupt or the counter clear.

Software reaches the block through a byte-wide register bus with a combinational read path. A counting tick comes from an external prescaler and is accepted only while the run bit is set. The pending flags for both sources and their 3-bit priorities sit in one shared interrupt byte. A source whose priority is zero keeps its request line low.

Top module: `ivtimer16`

## Requirements
- R1: While the run bit (bit 0 at address 0x9E) is 1, the counter advances by exactly one on each cycle with `tick_en` high and holds on cycles with `tick_en` low.
- R2: When the counter's next value equals the high compare value (bytes 0x92 low, 0x93 high), the counter becomes 0 and the high pending flag (bit 7 of the interrupt byte at 0xE6) is set, whatever the flip-flop control bits are.
- R3: When the counter's next value equals the low compare value (bytes 0x90 low, 0x91 high) and not the high one, the low pending flag (bit 3 of 0xE6) is set and counting continues without a clear.
- R4: The flip-flop output `tmr_ff` resets to 0. It inverts on a high match only if bit 3 of the flip-flop control byte (0x99) is 1, and on a low match only if bit 2 is 1. Otherwise it holds.
- R5: If both compares match on the same tick, only the high action is taken: the optional invert from bit 3, the clear, and bit 7. The low flag and the low invert are skipped.
- R6: Writing the run bit to 0 forces the counter to 0 and stops it. Setting the bit again restarts the count from 0.
- R7: Reading 0x99 returns the written byte OR 0xC3. Reading 0x98 returns the mode byte as written. The compare addresses 0x90 to 0x93 read as 0.
- R8: A pending flag stays set until a write to 0xE6 puts 0 in its bit. Writing 1 to a flag bit leaves it unchanged. Bits 6:4 (high) and 2:0 (low) of 0xE6 are writable priorities.
- R9: `irq_hi` equals bit 7 AND (bits 6:4 nonzero). `irq_lo` equals bit 3 AND (bits 2:0 nonzero). A priority of 0 masks the source while its flag is still visible.
- R10: A high compare value of 0 matches when the count wraps from 0xFFFF, giving one high event every 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tick_en | input | 1 | Prescaled count enable |
| tmr_ff | output | 1 | Timer flip-flop level |
| irq_lo | output | 1 | Low-compare interrupt request |
| irq_hi | output | 1 | High-compare interrupt request |

## Verification
Assertions check, on every cycle, that the counter holds without a tick, that a high hit clears it, that a low hit only advances it, that the flip-flop moves only on a hit, that stopping forces zero, and that pending flags are set on their hits and survive until written. Only the directed scenarios can show the tick counts from start to each match, which match wins when both hit together, the readback masks, the effect of priority masking on the request pins, and the 65536-tick period with a zero high compare.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int PRIO_W = 3;

    localparam logic [ADDR_W-1:0] A_CMPLO_L = 8'h90;
    localparam logic [ADDR_W-1:0] A_CMPLO_H = 8'h91;
    localparam logic [ADDR_W-1:0] A_CMPHI_L = 8'h92;
    localparam logic [ADDR_W-1:0] A_CMPHI_H = 8'h93;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'h98;
    localparam logic [ADDR_W-1:0] A_FFCTL   = 8'h99;
    localparam logic [ADDR_W-1:0] A_RUN     = 8'h9E;
    localparam logic [ADDR_W-1:0] A_IRQ     = 8'hE6;

    localparam logic [DATA_W-1:0] FFCTL_FORCE = 8'hC3;
    localparam int FF_INV_HI_BIT = 3;
    localparam int FF_INV_LO_BIT = 2;

    // One interrupt source: pending flag above its priority field
    typedef struct packed {
        logic              flag;
        logic [PRIO_W-1:0] prio;
    } irq_src_t;

    // Shared interrupt byte: high source in upper nibble
    typedef struct packed {
        irq_src_t hi;
        irq_src_t lo;
    } irq_reg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cmp_lo;
        logic [CNT_W-1:0] cmp_hi;
        logic             inv_hi;
        logic             inv_lo;
        logic             run;
    } tmr_cfg_t;

    typedef struct packed {
        logic hit_hi;
        logic hit_lo;
    } tmr_evt_t;

    function automatic logic src_request(irq_src_t s);
        return s.flag && (s.prio != '0);
    endfunction

    function automatic irq_src_t src_update(irq_src_t cur, logic wr,
                                            logic [PRIO_W:0] wbits, logic hit);
        irq_src_t n;
        n = cur;
        if (wr) begin
            n.prio = wbits[PRIO_W-1:0];
            n.flag = cur.flag & wbits[PRIO_W];
        end
        n.flag = n.flag | hit;
        return n;
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  irq_reg_t          irq_q,
    output tmr_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0]  cmp_lo_q, cmp_hi_q;
    logic [DATA_W-1:0] mode_q, ffctl_q;
    logic              run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            mode_q   <= '0;
            ffctl_q  <= '0;
            run_q    <= 1'b0;
        end else if (we) begin
            unique case (addr)
                A_CMPLO_L: cmp_lo_q[HALF-1:0]     <= wdata[HALF-1:0];
                A_CMPLO_H: cmp_lo_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
                A_CMPHI_L: cmp_hi_q[HALF-1:0]     <= wdata[HALF-1:0];
                A_CMPHI_H: cmp_hi_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
                A_MODE:    mode_q  <= wdata;
                A_FFCTL:   ffctl_q <= wdata;
                A_RUN:     run_q   <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.cmp_lo = cmp_lo_q;
        cfg.cmp_hi = cmp_hi_q;
        cfg.inv_hi = ffctl_q[FF_INV_HI_BIT];
        cfg.inv_lo = ffctl_q[FF_INV_LO_BIT];
        cfg.run    = run_q;
    end

    // Compare registers are write-only and fall to the default
    always_comb begin
        unique case (addr)
            A_MODE:  rdata = mode_q;
            A_FFCTL: rdata = ffctl_q | FFCTL_FORCE;
            A_RUN:   rdata = {{(DATA_W-1){1'b0}}, run_q};
            A_IRQ:   rdata = irq_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_cfg_t cfg,
    input  logic     tick_en,
    output tmr_evt_t evt,
    output logic     ff_q
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             step;

    assign step    = cfg.run && tick_en;
    assign cnt_nxt = cnt_q + 1'b1;

    // High compare takes precedence over low on a shared tick
    always_comb begin
        evt.hit_hi = step && (cnt_nxt == cfg.cmp_hi);
        evt.hit_lo = step && !evt.hit_hi && (cnt_nxt == cfg.cmp_lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ff_q  <= 1'b0;
        end else begin
            if (!cfg.run)
                cnt_q <= '0;
            else if (evt.hit_hi)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_nxt;

            if ((evt.hit_hi && cfg.inv_hi) || (evt.hit_lo && cfg.inv_lo))
                ff_q <= !ff_q;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg.run && !tick_en) |=> $stable(cnt_q)); // R1
    AST_HI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.hit_hi |=> (cnt_q == '0)); // R2
    AST_LO_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        evt.hit_lo |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_FF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!evt.hit_hi && !evt.hit_lo) |=> $stable(ff_q)); // R4
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  tmr_evt_t          evt,
    output irq_reg_t          irq_q,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int NIB = PRIO_W + 1;

    logic wr_irq;
    assign wr_irq = we && (addr == A_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q.hi <= src_update(irq_q.hi, wr_irq, wdata[2*NIB-1:NIB], evt.hit_hi);
            irq_q.lo <= src_update(irq_q.lo, wr_irq, wdata[NIB-1:0],     evt.hit_lo);
        end
    end

    assign irq_hi = src_request(irq_q.hi);
    assign irq_lo = src_request(irq_q.lo);

    AST_HI_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        evt.hit_hi |=> irq_q.hi.flag); // R2
    AST_LO_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        evt.hit_lo |=> irq_q.lo.flag); // R3
    AST_HI_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q.hi.flag && !wr_irq) |=> irq_q.hi.flag); // R8
    AST_LO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q.lo.flag && !wr_irq) |=> irq_q.lo.flag); // R8

endmodule

// File: rtl/ivtimer16.sv
module ivtimer16
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              tmr_ff,
    output logic              irq_lo,
    output logic              irq_hi
);
    tmr_cfg_t cfg;
    tmr_evt_t evt;
    irq_reg_t irq_q;

    ivt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .irq_q (irq_q),
        .cfg   (cfg),
        .rdata (bus_rdata)
    );

    ivt_core u_core (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .tick_en (tick_en),
        .evt     (evt),
        .ff_q    (tmr_ff)
    );

    ivt_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .evt    (evt),
        .irq_q  (irq_q),
        .irq_lo (irq_lo),
        .irq_hi (irq_hi)
    );

endmodule

// File: tb/ivtimer16_tb.sv
`timescale 1ns/1ps
module ivtimer16_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       tmr_ff, irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ivtimer16 u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .tmr_ff(tmr_ff), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic setup(logic [15:0] lo, logic [15:0] hi, logic [7:0] ffc, logic [7:0] irq);
        wr(8'h9E, 8'h00);
        wr(8'h90, lo[7:0]); wr(8'h91, lo[15:8]);
        wr(8'h92, hi[7:0]); wr(8'h93, hi[15:8]);
        wr(8'h99, ffc);
        wr(8'hE6, irq);
        wr(8'h9E, 8'h01);
    endtask

    task automatic irq_is(string req, logic [7:0] exp);
        logic [7:0] v;
        rd(8'hE6, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        irq_is("R8 reset irq byte", 8'h00);
        rd(8'h99, v); chk("R7 reset ffctl read", v, 8'hC3);
        chk("R4 reset ff", tmr_ff, 1'b0);
        chk("R9 reset irq pins", {irq_hi, irq_lo}, 2'b00);
    endtask

    task automatic t_basic();
        setup(16'd5, 16'd10, 8'h00, 8'h11);
        tick(4);  irq_is("R1 no flag before low match", 8'h11);
        repeat (3) @(negedge clk);
        tick(1);  irq_is("R3 low flag at 5th tick", 8'h19);
        chk("R9 low request", {irq_hi, irq_lo}, 2'b01);
        wr(8'hE6, 8'h19); irq_is("R8 writing 1 keeps flag", 8'h19);
        wr(8'hE6, 8'h11); irq_is("R8 writing 0 clears flag", 8'h11);
        tick(4);  irq_is("R3 counting continued after low match", 8'h11);
        tick(1);  irq_is("R2 high flag at 10th tick", 8'h91);
        chk("R2 high request", {irq_hi, irq_lo}, 2'b10);
        chk("R4 no invert with control bits clear", tmr_ff, 1'b0);
        tick(5);  irq_is("R2 counter cleared, low matches again", 8'h99);
        wr(8'hE6, 8'h11);
    endtask

    task automatic t_ff();
        logic [7:0] v;
        setup(16'd5, 16'd10, 8'h08, 8'h11);
        rd(8'h99, v); chk("R7 ffctl readback forced bits", v, 8'hCB);
        tick(10); chk("R4 invert on high match", tmr_ff, 1'b1);
        tick(5);  chk("R4 no invert on low match without bit 2", tmr_ff, 1'b1);
        wr(8'h99, 8'h04);
        rd(8'h99, v); chk("R7 ffctl readback", v, 8'hC7);
        tick(5);  chk("R4 no invert on high match without bit 3", tmr_ff, 1'b1);
        tick(5);  chk("R4 invert on low match", tmr_ff, 1'b0);
        wr(8'hE6, 8'h11);
    endtask

    task automatic t_both();
        setup(16'd7, 16'd7, 8'h04, 8'h11);
        tick(7);  irq_is("R5 only high flag on shared match", 8'h91);
        chk("R5 low invert skipped", tmr_ff, 1'b0);
        wr(8'hE6, 8'h11);
        tick(6);  irq_is("R5 counter cleared by shared match", 8'h11);
        tick(1);  irq_is("R5 next shared match", 8'h91);
        wr(8'hE6, 8'h11);
    endtask

    task automatic t_mask();
        setup(16'd3, 16'd100, 8'h00, 8'h01);
        tick(3);  irq_is("R9 low flag", 8'h09);
        chk("R9 low request unmasked", irq_lo, 1'b1);
        tick(97); irq_is("R9 high flag visible while masked", 8'h89);
        chk("R9 high request masked", irq_hi, 1'b0);
        wr(8'hE6, 8'h99);
        chk("R9 high request after unmask", irq_hi, 1'b1);
        wr(8'hE6, 8'h11);
    endtask

    task automatic t_stop();
        setup(16'd4, 16'd50, 8'h00, 8'h11);
        tick(3);
        wr(8'h9E, 8'h00);
        tick(10); irq_is("R6 no counting while stopped", 8'h11);
        wr(8'h9E, 8'h01);
        tick(3);  irq_is("R6 restart from zero", 8'h11);
        tick(1);  irq_is("R6 low match after restart", 8'h19);
        wr(8'hE6, 8'h11);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        rd(8'h90, v); chk("R7 compare low reads zero", v, 8'h00);
        rd(8'h93, v); chk("R7 compare high reads zero", v, 8'h00);
        wr(8'h98, 8'h5A);
        rd(8'h98, v); chk("R7 mode readback", v, 8'h5A);
    endtask

    task automatic t_wrap();
        setup(16'h8000, 16'h0000, 8'h00, 8'h11);
        tick(32767); irq_is("R10 nothing before 0x8000", 8'h11);
        tick(1);     irq_is("R10 low match at 0x8000", 8'h19);
        wr(8'hE6, 8'h11);
        tick(32767); irq_is("R10 no high match before wrap", 8'h11);
        tick(1);     irq_is("R10 high match on wrap", 8'h91);
        wr(8'hE6, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ff();
        t_both();
        t_mask();
        t_stop();
        t_reads();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule